// File: doc/BRIEF.md
# Half-Bridge Gate Command Sequencer

This block sits between a PWM generator and the two gate drivers of a half bridge. It takes a high-side command and a low-side command and produces the two gate enables. Each command first passes through a glitch filter. In guarded mode the block then makes sure the two enables are never on together, and it holds a fixed quiet gap after one enable drops before the other may rise. In bypass mode both enables follow their own commands independently.

Each enable is also gated by two supply-good flags that come from an external lockout monitor. When the low-side supply is bad, both enables are held off. When the high-side supply is bad, only the high-side enable is held off. After the high-side supply comes back, its enable must be re-armed by a new rising command. After the low-side supply comes back, the low-side enable simply takes the level of its command again.

Filter length `FILT_CYC` and quiet gap `DEAD_CYC` are set in clock cycles. Each must be at least 1.

Top module: `hb_gate_ctrl`

## Requirements
- R1: A command level that lasts fewer than FILT_CYC consecutive cycles has no effect on either enable. This holds both for high pulses and for low gaps in a held-high command. A level that lasts FILT_CYC cycles or more is passed on.
- R2: When nothing else blocks it, an enable takes a new command level on the (FILT_CYC+1)-th rising clock edge after the first edge that samples the change. This latency is the same for turn-on and turn-off.
- R3: In guarded mode (no_guard = 0), hs_gate and ls_gate are never 1 in the same cycle. If both filtered commands are high, both enables are 0.
- R4: In guarded mode, when one enable falls and the other command is already high, the other enable rises after exactly DEAD_CYC cycles in which both are 0. When a both-high conflict ends, the remaining enable rises DEAD_CYC cycles after the other filtered command falls.
- R5: In bypass mode (no_guard = 1), the two enables are independent. Both may be 1 together, and a handover inserts no cycle with both enables at 0.
- R6: hs_gate and ls_gate are both 0 on the clock edge after ls_supply_ok is sampled at 0.
- R7: hs_gate is 0 on the clock edge after hs_supply_ok is sampled at 0. ls_gate is not affected.
- R8: After hs_supply_ok returns to 1, hs_gate stays 0 while hi_cmd remains high. It turns on only after a new filtered rising edge of hi_cmd, following the R2 latency.
- R9: After ls_supply_ok returns to 1, ls_gate takes the level of the filtered lo_cmd on the next edge, with no new edge needed. hs_gate does the same if the high side stayed re-armed.
- R10: While rst is high, and after reset with both commands held low, both enables are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hi_cmd | input | 1 | High-side PWM command |
| lo_cmd | input | 1 | Low-side PWM command |
| hs_supply_ok | input | 1 | High-side supply good (0 = lockout) |
| ls_supply_ok | input | 1 | Low-side supply good (0 = lockout, blocks both sides) |
| no_guard | input | 1 | 1 = bypass quiet gap and interlock, 0 = guarded |
| hs_gate | output | 1 | High-side gate enable, registered |
| ls_gate | output | 1 | Low-side gate enable, registered |

## Verification
The interlock and quiet-gap properties assume that no_guard has been steady for at least a cycle. They also assume the mode is not flipped into guarded while an enable is about to rise. The stimulus therefore changes no_guard only together with commands that drive both enables off, and then waits longer than the filter plus the gap.

The supply flags are treated as synchronous to clk. The stimulus changes them only at the falling clock edge. It also holds each command level far longer than FILT_CYC, except where a short pulse is the point of the test.

// File: rtl/hbg_pkg.sv
package hbg_pkg;
  typedef struct packed {
    logic hs;
    logic ls;
  } gate_pair_t;
endpackage

// File: rtl/hbg_glitch_filter.sv
module hbg_glitch_filter #(
  parameter int unsigned FILT_CYC = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  localparam int unsigned CW = $clog2(FILT_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(FILT_CYC - 1);

  logic [CW-1:0] run_q;

  // output moves only after din has differed from it for FILT_CYC samples
  always_ff @(posedge clk) begin
    if (rst) begin
      dout  <= 1'b0;
      run_q <= '0;
    end else if (din == dout) begin
      run_q <= '0;
    end else if (run_q == LAST) begin
      dout  <= din;
      run_q <= '0;
    end else begin
      run_q <= run_q + 1'b1;
    end
  end
endmodule

// File: rtl/hbg_rearm.sv
module hbg_rearm
  import hbg_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       hs_ok,
  input  logic       ls_ok,
  input  logic       hin_f,
  input  logic       lin_f,
  output gate_pair_t req
);
  logic hin_q;
  logic armed_q;
  logic rise;

  always_comb begin
    rise   = hin_f & ~hin_q;
    req.hs = hin_f & hs_ok & ls_ok & (armed_q | rise);
    req.ls = lin_f & ls_ok;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hin_q   <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      hin_q   <= hin_f;
      armed_q <= hs_ok & (armed_q | rise);
    end
  end
endmodule

// File: rtl/hbg_dead_lock.sv
module hbg_dead_lock
  import hbg_pkg::*;
#(
  parameter int unsigned DEAD_CYC = 6
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       bypass,
  input  gate_pair_t req,
  output gate_pair_t gate
);
  localparam int unsigned CW = $clog2(DEAD_CYC + 1);
  localparam logic [CW-1:0] RELOAD = CW'(DEAD_CYC - 1);

  logic [CW-1:0] dcnt_q;
  gate_pair_t    nxt;
  logic          idle;
  logic          drop;
  logic          clash;

  always_comb begin
    idle  = (dcnt_q == '0);
    clash = req.hs & req.ls;
    if (bypass) begin
      nxt = req;
    end else begin
      nxt.hs = req.hs & ~req.ls & ~gate.ls & (gate.hs | idle);
      nxt.ls = req.ls & ~req.hs & ~gate.hs & (gate.ls | idle);
    end
    drop = (gate.hs & ~nxt.hs) | (gate.ls & ~nxt.ls);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gate   <= '0;
      dcnt_q <= '0;
    end else begin
      gate <= nxt;
      if (bypass)
        dcnt_q <= '0;
      else if (drop | clash)
        dcnt_q <= RELOAD;
      else if (!idle)
        dcnt_q <= dcnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/hb_gate_ctrl.sv
module hb_gate_ctrl
  import hbg_pkg::*;
#(
  parameter int unsigned FILT_CYC = 4,
  parameter int unsigned DEAD_CYC = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic hi_cmd,
  input  logic lo_cmd,
  input  logic hs_supply_ok,
  input  logic ls_supply_ok,
  input  logic no_guard,
  output logic hs_gate,
  output logic ls_gate
);
  localparam int unsigned NCH = 2;

  logic [NCH-1:0] cmd;
  logic [NCH-1:0] filt;
  logic           hin_filt;
  gate_pair_t     req;
  gate_pair_t     gate;

  assign cmd = {hi_cmd, lo_cmd};

  for (genvar i = 0; i < NCH; i++) begin : g_filt
    hbg_glitch_filter #(.FILT_CYC(FILT_CYC)) u_filt (
      .clk  (clk),
      .rst  (rst),
      .din  (cmd[i]),
      .dout (filt[i])
    );
  end

  assign hin_filt = filt[1];

  hbg_rearm u_rearm (
    .clk   (clk),
    .rst   (rst),
    .hs_ok (hs_supply_ok),
    .ls_ok (ls_supply_ok),
    .hin_f (hin_filt),
    .lin_f (filt[0]),
    .req   (req)
  );

  hbg_dead_lock #(.DEAD_CYC(DEAD_CYC)) u_dead (
    .clk    (clk),
    .rst    (rst),
    .bypass (no_guard),
    .req    (req),
    .gate   (gate)
  );

  assign hs_gate = gate.hs;
  assign ls_gate = gate.ls;
endmodule

// File: rtl/hbg_gate_checker.sv
module hbg_gate_checker #(
  parameter int unsigned DEAD_CYC = 6
) (
  input logic clk,
  input logic rst,
  input logic no_guard,
  input logic hs_supply_ok,
  input logic ls_supply_ok,
  input logic hs_gate,
  input logic ls_gate,
  input logic hin_f
);
  localparam int unsigned CW = $clog2(DEAD_CYC + 1);
  localparam logic [CW-1:0] SAT = CW'(DEAD_CYC);

  logic [CW-1:0] since_hs;
  logic [CW-1:0] since_ls;

  always_ff @(posedge clk) begin
    if (rst) begin
      since_hs <= SAT;
      since_ls <= SAT;
    end else begin
      since_hs <= hs_gate ? '0 : ((since_hs == SAT) ? SAT : since_hs + 1'b1);
      since_ls <= ls_gate ? '0 : ((since_ls == SAT) ? SAT : since_ls + 1'b1);
    end
  end

  // R3
  interlock_chk: assert property (@(posedge clk) disable iff (rst)
    $past(!no_guard) |-> !(hs_gate && ls_gate));

  // R4
  gap_before_hs_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(!no_guard) && $rose(hs_gate)) |-> (since_ls >= SAT));

  // R4
  gap_before_ls_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(!no_guard) && $rose(ls_gate)) |-> (since_hs >= SAT));

  // R6
  ls_lockout_chk: assert property (@(posedge clk) disable iff (rst)
    $past(!ls_supply_ok) |-> (!hs_gate && !ls_gate));

  // R7
  hs_lockout_chk: assert property (@(posedge clk) disable iff (rst)
    $past(!hs_supply_ok) |-> !hs_gate);

  // R8
  hs_source_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(hs_gate) |-> $past(hin_f));
endmodule

bind hb_gate_ctrl hbg_gate_checker #(.DEAD_CYC(DEAD_CYC)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .no_guard     (no_guard),
  .hs_supply_ok (hs_supply_ok),
  .ls_supply_ok (ls_supply_ok),
  .hs_gate      (hs_gate),
  .ls_gate      (ls_gate),
  .hin_f        (hin_filt)
);

// File: tb/tb_hb_gate_ctrl.sv
module tb_hb_gate_ctrl;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int FILT = 4;
  localparam int DEAD = 6;
  localparam int SETTLE = 24;
  localparam int NVEC = 13;

  // {no_guard, hs_ok, ls_ok, hi, lo, exp_hs, exp_ls}
  localparam logic [6:0] VEC [NVEC] = '{
    7'b0110000,  // idle                    R10
    7'b0111010,  // high side on            R2
    7'b0110101,  // handover to low         R4
    7'b0111100,  // both commands high      R3
    7'b0111010,  // back to high            R4
    7'b1111111,  // bypass both on          R5
    7'b1011101,  // high supply lost        R7
    7'b1111101,  // recovered, no edge      R8
    7'b1110101,  // hi dropped
    7'b1111111,  // new edge re-arms        R8
    7'b1101100,  // low supply lost         R6
    7'b1111111,  // low supply back         R9
    7'b0110000   // guarded idle
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic hi_cmd = 1'b0, lo_cmd = 1'b0;
  logic hs_ok = 1'b1, ls_ok = 1'b1, no_guard = 1'b0;
  logic hs_gate, ls_gate;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4ns clk = ~clk;

  hb_gate_ctrl #(.FILT_CYC(FILT), .DEAD_CYC(DEAD)) dut (
    .clk (clk), .rst (rst), .hi_cmd (hi_cmd), .lo_cmd (lo_cmd),
    .hs_supply_ok (hs_ok), .ls_supply_ok (ls_ok), .no_guard (no_guard),
    .hs_gate (hs_gate), .ls_gate (ls_gate)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic go_idle();
    @(negedge clk);
    hi_cmd = 1'b0; lo_cmd = 1'b0; hs_ok = 1'b1; ls_ok = 1'b1;
    wait_n(SETTLE);
    no_guard = 1'b0;
    wait_n(2);
  endtask

  // samples until the chosen output reaches lvl; returns sample count
  task automatic until_out(input bit hs_side, input logic lvl, output int n);
    n = 0;
    for (int i = 0; i < 80; i++) begin
      @(negedge clk);
      n++;
      if ((hs_side ? hs_gate : ls_gate) == lvl) break;
    end
  endtask

  // counts samples with both outputs low until the chosen output is high
  task automatic count_quiet(input bit hs_side, output int n);
    n = 0;
    for (int i = 0; i < 80; i++) begin
      @(negedge clk);
      if (!hs_gate && !ls_gate) n++;
      if (hs_side ? hs_gate : ls_gate) break;
    end
  endtask

  initial begin
    int n;
    logic seen;
    wait_n(3);
    chk("R10", "hs_gate in reset", hs_gate, 0);
    chk("R10", "ls_gate in reset", ls_gate, 0);
    rst = 1'b0;
    wait_n(SETTLE);
    chk("R10", "hs_gate after reset", hs_gate, 0);
    chk("R10", "ls_gate after reset", ls_gate, 0);

    for (int i = 0; i < NVEC; i++) begin
      {no_guard, hs_ok, ls_ok, hi_cmd, lo_cmd} = VEC[i][6:2];
      wait_n(SETTLE);
      chk($sformatf("table step %0d", i), "hs_gate", hs_gate, VEC[i][1]);
      chk($sformatf("table step %0d", i), "ls_gate", ls_gate, VEC[i][0]);
    end
    go_idle();

    // R2 latency on both edges
    lo_cmd = 1'b1;
    until_out(1'b0, 1'b1, n);
    chk("R2", "turn-on latency", n, FILT + 1);
    wait_n(4);
    lo_cmd = 1'b0;
    until_out(1'b0, 1'b0, n);
    chk("R2", "turn-off latency", n, FILT + 1);
    go_idle();

    // R1 short pulse rejected, full-length pulse accepted, short gap ignored
    hi_cmd = 1'b1; wait_n(FILT - 1); hi_cmd = 1'b0;
    seen = 1'b0;
    for (int i = 0; i < 3 * FILT; i++) begin @(negedge clk); seen |= hs_gate; end
    chk("R1", "short pulse reached hs_gate", seen, 0);
    hi_cmd = 1'b1; wait_n(FILT); hi_cmd = 1'b0;
    seen = 1'b0;
    for (int i = 0; i < 3 * FILT; i++) begin @(negedge clk); seen |= hs_gate; end
    chk("R1", "full pulse reached hs_gate", seen, 1);
    hi_cmd = 1'b1; wait_n(SETTLE);
    hi_cmd = 1'b0; wait_n(FILT - 1); hi_cmd = 1'b1;
    seen = 1'b1;
    for (int i = 0; i < 3 * FILT; i++) begin @(negedge clk); seen &= hs_gate; end
    chk("R1", "short gap kept hs_gate high", seen, 1);
    go_idle();

    // R4 handover gap
    hi_cmd = 1'b1; wait_n(SETTLE);
    hi_cmd = 1'b0; lo_cmd = 1'b1;
    count_quiet(1'b0, n);
    chk("R4", "quiet cycles on handover", n, DEAD);
    chk("R4", "ls_gate after handover", ls_gate, 1);
    go_idle();

    // R3 conflict, then R4 gap after conflict ends
    hi_cmd = 1'b1; lo_cmd = 1'b1; wait_n(SETTLE);
    chk("R3", "hs_gate in conflict", hs_gate, 0);
    chk("R3", "ls_gate in conflict", ls_gate, 0);
    lo_cmd = 1'b0;
    count_quiet(1'b1, n);
    chk("R4", "quiet samples after conflict", n, FILT + DEAD - 1);
    go_idle();

    // R5 bypass handover has no gap
    no_guard = 1'b1;
    hi_cmd = 1'b1; wait_n(SETTLE);
    hi_cmd = 1'b0; lo_cmd = 1'b1;
    count_quiet(1'b0, n);
    chk("R5", "quiet cycles in bypass", n, 0);
    go_idle();

    // R7 and R8: lockout, recovery without edge, re-arm by edge
    hi_cmd = 1'b1; wait_n(SETTLE);
    hs_ok = 1'b0; @(negedge clk);
    chk("R7", "hs_gate one edge after lockout", hs_gate, 0);
    hs_ok = 1'b1;
    seen = 1'b0;
    for (int i = 0; i < 3 * FILT; i++) begin @(negedge clk); seen |= hs_gate; end
    chk("R8", "hs_gate without new edge", seen, 0);
    hi_cmd = 1'b0; wait_n(FILT + 2);
    hi_cmd = 1'b1;
    until_out(1'b1, 1'b1, n);
    chk("R8", "re-arm latency", n, FILT + 1);
    go_idle();

    // R6 and R9 in bypass with both on, then R7 leaves ls_gate alone
    no_guard = 1'b1;
    hi_cmd = 1'b1; lo_cmd = 1'b1; wait_n(SETTLE);
    ls_ok = 1'b0; @(negedge clk);
    chk("R6", "hs_gate after low lockout", hs_gate, 0);
    chk("R6", "ls_gate after low lockout", ls_gate, 0);
    wait_n(5);
    ls_ok = 1'b1; @(negedge clk);
    chk("R9", "ls_gate one edge after recovery", ls_gate, 1);
    chk("R9", "hs_gate one edge after recovery", hs_gate, 1);
    hs_ok = 1'b0; @(negedge clk);
    chk("R7", "hs_gate in high lockout", hs_gate, 0);
    chk("R7", "ls_gate in high lockout", ls_gate, 1);
    go_idle();

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(8ns * 150000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule